// File: doc/BRIEF.md
# Masked Two-Wire Slave Address Matcher

This block decides whether an address byte received on a two-wire serial bus selects the local slave. The byte holds seven address bits in positions 7:1 and the read/write flag in position 0. The block compares it with a programmed own-address register. Any bit position flagged in a separate mask register is left out of the comparison, so one slave can answer a whole programmable group of addresses.

The block also recognises the general call address, a byte of all zeros, when the enable bit in bit 0 of the own-address register is set. A byte-valid strobe starts each comparison. One cycle later the block raises a single-cycle match pulse. With that pulse it gives a flag telling whether the general call path produced the match, and it passes the received read/write bit through. Software writes the two registers through a small select/write-enable port and reads them back through the same port. The shift logic, the acknowledge and the data phase are handled elsewhere.

Top module: `addr_matcher`

## Requirements
- R1: After reset both registers read 0x00. `hit`, `hit_gc` and `hit_rw` are low.
- R2: With `addr_vld` high in cycle t, `hit` is high in cycle t+1 when every unmasked bit of `addr_byte[7:1]` equals the same bit of the own-address register. `addr_byte[0]` takes no part in this comparison.
- R3: A mask register bit k of 1 (k in 7:1) excludes position k from the comparison, so a difference in that position still gives `hit`.
- R4: `reg_sel`=0 selects the own-address register and `reg_sel`=1 selects the mask register. A write stores `reg_wdata` into the selected register. The own-address register reads back all 8 bits. Bit 0 of the mask register always reads 0.
- R5: When own-address bit 0 (general call enable) is 1, a received byte of 0x00 gives `hit` with `hit_gc`=1, whatever the mask contents.
- R6: When the general call enable is 0, a received byte of 0x00 gives no `hit` unless the own-address comparison matches.
- R7: The byte 0x01 (zero address, read) is never treated as a general call, so `hit_gc` stays 0.
- R8: When the own-address comparison and the general call both match, `hit` is 1 and `hit_gc` is 0.
- R9: `hit` is high for exactly one cycle per matching strobe. Without a strobe in the previous cycle, `hit` is 0.
- R10: When `hit` is 1, `hit_rw` equals bit 0 of the byte that caused the match. Otherwise `hit_rw` and `hit_gc` are 0.
- R11: A register write in the same cycle as a strobe does not change the result of that comparison. It applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Received address byte is valid this cycle |
| addr_byte | input | 8 | Address in bits 7:1, read/write flag in bit 0 |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 = own-address register, 1 = mask register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| hit | output | 1 | One-cycle match pulse |
| hit_gc | output | 1 | Match came from the general call path |
| hit_rw | output | 1 | Read/write bit of the matched byte |

## Verification
The checker covers, on every cycle, the one-cycle pulse timing against the strobe and the flags that must stay low without a match. It also checks that a general-call flag appears only for an all-zero byte and with a match, that the read/write bit follows the strobed byte, and that the mask register's bit 0 always reads zero. Some behaviours depend on register contents and their history, so only the bench scenarios can show them. These are the masked comparison itself, the enable gating, own-address priority, and the ordering of a write against a strobe in the same cycle. A behavioural model run alongside the design checks them over directed and random traffic.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

    parameter int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rw;
    } addr_byte_t;

    typedef enum logic {
        SEL_OWN  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic hit;
        logic gc;
        logic rw;
    } match_res_t;

    localparam match_res_t NO_MATCH = '{hit: 1'b0, gc: 1'b0, rw: 1'b0};

    // True when the byte is the all-zero general call pattern (write)
    function automatic logic is_gcall(input addr_byte_t b);
        return (b.addr == '0) && !b.rw;
    endfunction

endpackage

// File: rtl/amatch_regs.sv
module amatch_regs
    import amatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] own_addr,
    output logic              gc_en,
    output logic [ADDR_W-1:0] mask
);
    logic [ADDR_W-1:0] own_q;
    logic              gc_q;
    logic [ADDR_W-1:0] mask_q;
    reg_sel_e          sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            gc_q   <= 1'b0;
            mask_q <= '0;
        end else if (we) begin
            if (sel_e == SEL_OWN) begin
                own_q <= wdata[BYTE_W-1:1];
                gc_q  <= wdata[0];
            end else begin
                mask_q <= wdata[BYTE_W-1:1];
            end
        end
    end

    always_comb begin
        if (sel_e == SEL_OWN) rdata = {own_q, gc_q};
        else                  rdata = {mask_q, 1'b0};
    end

    assign own_addr = own_q;
    assign gc_en    = gc_q;
    assign mask     = mask_q;
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp
    import amatch_pkg::*;
(
    input  logic              vld,
    input  addr_byte_t        rx,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] mask,
    output match_res_t        res
);
    logic [ADDR_W-1:0] bit_ok;
    logic              own_hit;
    logic              gc_hit;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(rx.addr[i] ^ own_addr[i]);
    end

    assign own_hit = &bit_ok;
    assign gc_hit  = gc_en & is_gcall(rx);

    always_comb begin
        res = NO_MATCH;
        if (vld && (own_hit || gc_hit)) begin
            res.hit = 1'b1;
            res.gc  = !own_hit;
            res.rw  = rx.rw;
        end
    end
endmodule

// File: rtl/amatch_out.sv
module amatch_out
    import amatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  match_res_t d,
    output match_res_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= NO_MATCH;
        else     q <= d;
    end
endmodule

// File: rtl/addr_matcher.sv
module addr_matcher
    import amatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_vld,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              hit,
    output logic              hit_gc,
    output logic              hit_rw
);
    logic [ADDR_W-1:0] own_addr;
    logic              gc_en;
    logic [ADDR_W-1:0] mask;
    match_res_t        res_d;
    match_res_t        res_q;

    amatch_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .mask     (mask)
    );

    amatch_cmp u_cmp (
        .vld      (addr_vld),
        .rx       (addr_byte_t'(addr_byte)),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .mask     (mask),
        .res      (res_d)
    );

    amatch_out u_out (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign hit    = res_q.hit;
    assign hit_gc = res_q.gc;
    assign hit_rw = res_q.rw;
endmodule

// File: rtl/addr_matcher_chk.sv
module addr_matcher_chk
    import amatch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              addr_vld,
    input logic [BYTE_W-1:0] addr_byte,
    input logic              reg_sel,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              hit,
    input logic              hit_gc,
    input logic              hit_rw
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!hit && !hit_gc && !hit_rw));

    assert_mask_lsb_zero_R4: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> !reg_rdata[0]);

    assert_gc_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
        hit_gc |-> hit);

    assert_gc_only_zero_byte_R7: assert property (@(posedge clk) disable iff (rst)
        hit_gc |-> ($past(addr_byte) == '0));

    assert_hit_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(addr_vld));

    assert_rw_follows_byte_R10: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_rw == $past(addr_byte[0])));

    assert_flags_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!hit_rw && !hit_gc));
endmodule

bind addr_matcher addr_matcher_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_vld  (addr_vld),
    .addr_byte (addr_byte),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .hit       (hit),
    .hit_gc    (hit_gc),
    .hit_rw    (hit_rw)
);

// File: tb/sim_addr_matcher.sv
module sim_addr_matcher;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_vld = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       hit, hit_gc, hit_rw;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model state
    logic [7:0] m_own = 8'h00;
    logic [7:0] m_mask = 8'h00;
    logic       e_hit = 1'b0, e_gc = 1'b0, e_rw = 1'b0;

    always #2 clk = ~clk;

    addr_matcher u0 (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr_byte(addr_byte),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hit(hit), .hit_gc(hit_gc), .hit_rw(hit_rw)
    );

    function automatic bit own_match(input logic [7:0] b, input logic [7:0] own,
                                     input logic [7:0] msk);
        for (int k = 1; k < 8; k++)
            if (!msk[k] && (b[k] != own[k])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] e_rd;
        e_rd = reg_sel ? {m_mask[7:1], 1'b0} : m_own;
        total++;
        if (hit !== e_hit || hit_gc !== e_gc || hit_rw !== e_rw || reg_rdata !== e_rd) begin
            bad++;
            $display("FAIL %s: actual hit=%b gc=%b rw=%b rd=%h expected hit=%b gc=%b rw=%b rd=%h",
                     tag, hit, hit_gc, hit_rw, reg_rdata, e_hit, e_gc, e_rw, e_rd);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic v, input logic [7:0] b, input logic we,
                        input logic sel, input logic [7:0] wd, input string tag);
        bit om, gm;
        addr_vld = v; addr_byte = b; reg_we = we; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        om = own_match(b, m_own, m_mask);
        gm = m_own[0] && (b == 8'h00);
        e_hit = v && (om || gm);
        e_gc  = v && gm && !om;
        e_rw  = v && (om || gm) && b[0];
        if (we) begin
            if (sel) m_mask = {wd[7:1], 1'b0};
            else     m_own  = wd;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic sel, input logic [7:0] wd, input string tag);
        step(1'b0, 8'h00, 1'b1, sel, wd, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of both registers and outputs
        compare("R1 own reg");
        reg_sel = 1'b1; #0; compare("R1 mask reg");
        // R2/R10: zero own address after reset, read byte matches
        step(1'b1, 8'h01, 1'b0, 1'b0, 8'h00, "R2 R10 zero address read");
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R9 pulse ends");
        // R4: register writes and read back
        wr(1'b0, 8'h55, "R4 own readback");
        wr(1'b1, 8'h07, "R4 mask bit0 reads zero");
        wr(1'b1, 8'h00, "R4 clear mask");
        step(1'b1, 8'h54, 1'b0, 1'b0, 8'h00, "R2 exact write");
        step(1'b1, 8'h55, 1'b0, 1'b0, 8'h00, "R10 exact read");
        step(1'b1, 8'h56, 1'b0, 1'b0, 8'h00, "R2 bit1 differs");
        step(1'b0, 8'h54, 1'b0, 1'b0, 8'h00, "R9 no strobe");
        // R3: masked positions
        wr(1'b1, 8'h06, "R3 mask set");
        step(1'b1, 8'h52, 1'b0, 1'b0, 8'h00, "R3 masked diff");
        step(1'b1, 8'h5C, 1'b0, 1'b0, 8'h00, "R3 unmasked diff");
        // R5/R7: general call
        step(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R5 general call");
        step(1'b1, 8'h01, 1'b0, 1'b0, 8'h00, "R7 zero read not gcall");
        wr(1'b1, 8'hFE, "R5 full mask");
        step(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R8 full mask own wins");
        wr(1'b1, 8'h00, "R5 clear mask");
        // R6: disabled general call
        wr(1'b0, 8'h54, "R6 disable gcall");
        step(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R6 gcall ignored");
        // R8: own address zero with gcall enabled
        wr(1'b0, 8'h01, "R8 own zero");
        step(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R8 own priority");
        // R11: same-cycle write does not affect the comparison
        wr(1'b0, 8'h54, "R11 setup");
        step(1'b1, 8'h54, 1'b1, 1'b0, 8'h20, "R11 old value used");
        step(1'b1, 8'h54, 1'b0, 1'b0, 8'h00, "R11 new value applies");
        step(1'b1, 8'h20, 1'b1, 1'b1, 8'hFE, "R11 mask write same cycle");
        step(1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, "R11 mask applies next");
        // random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            logic [7:0] rb, rw;
            rb = $urandom;
            rw = $urandom;
            if (rb[7:4] < 4) rb = (rw[0]) ? 8'h00 : 8'h01;
            step(rw[1] | rw[2], rb, rw[3] & rw[4] & rw[5], rw[6], $urandom,
                 "R2 R3 R5 R8 random");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule